// File: doc/BRIEF.md
# Bit-Serial Reordered Normal Basis Field Multiplier

This block multiplies two elements of the binary extension field GF(2^m). Elements are written in a reordered normal basis. That basis is a fixed permutation of a type II optimal normal basis, so results can be moved to that basis by rewiring bits only. The field size `M` defaults to 233. It is a parameter, so the same code also runs at small sizes, as long as `2M+1` is prime.

The B operand is loaded in parallel when a start pulse is accepted. The A operand then arrives one coefficient per clock on a serial input. A chain of `M` identical cells builds the product. In each step, each cell takes the current serial bit, ANDs it with the XOR of two stored B coefficients, and toggles its single state bit when the result is one. The product coefficients are therefore all ready at once after `M` steps. A one-cycle done pulse marks that moment, and the product holds until the next start.

Coefficient `k` (numbered 1..M) lives in bit `k-1` of every vector port. All state updates on the falling clock edge. The external reset is asynchronous and active low, and it is released through a two-stage synchronizer.

Top module: `rnb_mult`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `done` are 0 and `prod` is all zeros.
- R2: A `start` high at a falling edge while `busy` is 0 captures `b_in`, clears `prod` to zero and raises `busy` at that edge.
- R3: After an accepted start, exactly `M` more falling edges each consume one `a_bit`, with a_1 at the first of them. `busy` drops and `done` rises at the edge that consumes a_M. `done` stays high for exactly one cycle.
- R4: When `done` is high, coefficient k of `prod` equals the XOR over i=1..M of a_i AND (b_s(k+i) XOR b_s(k-i)). Here s(x) is x mod (2M+1) if that residue is at most M, and 2M+1 minus it otherwise, and b_0 counts as 0.
- R5: A `start` pulse while `busy` is 1 is ignored. The product, the captured B and the timing of `done` are unchanged.
- R6: While `busy` is 0 and `start` is low, `prod` does not change.
- R7: Multiplying by the all-ones vector returns the other operand unchanged.
- R8: The product is commutative: swapping the A and B operands gives the same `prod`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin a multiplication (ignored while busy) |
| b_in | input | M | Parallel operand, captured at an accepted start |
| a_bit | input | 1 | Serial operand, coefficient a_1 first |
| busy | output | 1 | High while serial bits are being consumed |
| done | output | 1 | One-cycle pulse when the product is complete |
| prod | output | M | Accumulated product coefficients |

## Verification
At M=5 (modulus 11), the bench runs every pair of A and B operands and compares each product with a behavioural model of the folded-index formula. Sparse operands (single ones) check each pair of folded taps on its own. Dense operands check how the XOR chains cancel. Once all runs are done, the collected results are checked for the all-ones identity and for symmetry under swapping operands. These two checks can expose a consistent mistake in the tap wiring that the model might share. Some runs get a start pulse in the middle of the operation, to show that the pulse has no effect on the result or on when `done` appears.

// File: rtl/rnb_pkg.sv
package rnb_pkg;

  // Fold a residue modulo 2m+1 onto the coefficient index range 0..m.
  function automatic int unsigned rnb_fold(input int unsigned x, input int unsigned m);
    int unsigned p;
    int unsigned r;
    p = 2 * m + 1;
    r = x % p;
    if (r <= m) return r;
    else        return p - r;
  endfunction

endpackage

// File: rtl/rnb_bext.sv
// Expands the m-bit operand into a 2m+1 entry ring indexed by residue,
// pre-rotated by one position so that the first serial step sees offset 1.
module rnb_bext #(
  parameter int unsigned M = 233,
  localparam int unsigned P = 2 * M + 1
) (
  input  logic [M-1:0] b,
  output logic [P-1:0] ring
);
  for (genvar j = 0; j < P; j++) begin : g_tap
    localparam int unsigned IDX = rnb_pkg::rnb_fold(j + 1, M);
    if (IDX == 0) begin : g_zero
      assign ring[j] = 1'b0;
    end else begin : g_bit
      assign ring[j] = b[IDX-1];
    end
  end
endmodule

// File: rtl/rnb_rot_reg.sv
// Circular register: parallel load, or rotate one place toward index 0.
module rnb_rot_reg #(
  parameter int unsigned W = 467
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load)       q_nxt = d;
    else if (shift) q_nxt = {q[0], q[W-1:1]};
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/rnb_cell.sv
// One product coefficient: toggles when a AND (b_fwd XOR b_bwd) is set.
module rnb_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic a_bit,
  input  logic b_fwd,
  input  logic b_bwd,
  output logic acc
);
  logic term;
  logic acc_nxt;

  always_comb begin
    term    = en & a_bit & (b_fwd ^ b_bwd);
    acc_nxt = acc;
    if (clr)       acc_nxt = 1'b0;
    else if (term) acc_nxt = ~acc;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) acc <= 1'b0;
    else        acc <= acc_nxt;
  end
endmodule

// File: rtl/rnb_ctrl.sv
// Sequencer: accepts start when idle, counts M serial steps, pulses done.
module rnb_ctrl #(
  parameter int unsigned M = 233,
  localparam int unsigned CW = $clog2(M + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  logic [CW-1:0] cnt, cnt_nxt;
  logic          busy_nxt, done_nxt;

  assign load = start & ~busy;
  assign step = busy;

  always_comb begin
    cnt_nxt  = cnt;
    busy_nxt = busy;
    done_nxt = 1'b0;
    if (load) begin
      cnt_nxt  = CW'(1);
      busy_nxt = 1'b1;
    end else if (busy) begin
      if (cnt == CW'(M)) begin
        busy_nxt = 1'b0;
        done_nxt = 1'b1;
        cnt_nxt  = '0;
      end else begin
        cnt_nxt = cnt + CW'(1);
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      busy <= busy_nxt;
      done <= done_nxt;
    end
  end
endmodule

// File: rtl/rnb_mult.sv
module rnb_mult #(
  parameter int unsigned M = 233
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] b_in,
  input  logic         a_bit,
  output logic         busy,
  output logic         done,
  output logic [M-1:0] prod
);
  localparam int unsigned P = 2 * M + 1;

  // Reset synchronizer: asynchronous assert, release after two falling edges.
  logic [1:0] rst_q;
  logic       rst_sync_n;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  logic         load, step;
  logic [P-1:0] ring_init, ring;

  rnb_ctrl #(.M(M)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  rnb_bext #(.M(M)) u_bext (
    .b    (b_in),
    .ring (ring_init)
  );

  rnb_rot_reg #(.W(P)) u_ring (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (load),
    .shift (step),
    .d     (ring_init),
    .q     (ring)
  );

  // Cell k reads ring positions k (offset +i) and P-k (offset -i).
  for (genvar k = 1; k <= M; k++) begin : g_cell
    rnb_cell u_cell (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (load),
      .en    (step),
      .a_bit (a_bit),
      .b_fwd (ring[k]),
      .b_bwd (ring[P-k]),
      .acc   (prod[k-1])
    );
  end
endmodule

// File: rtl/rnb_mult_chk.sv
module rnb_mult_chk #(
  parameter int unsigned M = 233,
  localparam int unsigned CW = $clog2(M + 2)
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [M-1:0] prod
);
  logic [CW-1:0] run_len;

  always_ff @(negedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  run_len <= '0;
    else if (busy)    run_len <= run_len + CW'(1);
    else              run_len <= '0;
  end

  a_r1_idle_reset: assert property (@(negedge clk) !rst_sync_n |-> (!busy && !done));

  a_r2_start_clears: assert property (@(negedge clk) disable iff (!rst_sync_n)
    (!busy && start) |=> (busy && prod == '0));

  a_r3_done_single: assert property (@(negedge clk) disable iff (!rst_sync_n)
    done |=> !done);

  a_r3_done_on_fall: assert property (@(negedge clk) disable iff (!rst_sync_n)
    $fell(busy) |-> done);

  a_r3_run_length: assert property (@(negedge clk) disable iff (!rst_sync_n)
    $fell(busy) |-> (run_len == CW'(M)));

  a_r6_idle_hold: assert property (@(negedge clk) disable iff (!rst_sync_n)
    (!busy && !start) |=> $stable(prod));
endmodule

bind rnb_mult rnb_mult_chk #(.M(M)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .prod       (prod)
);

// File: tb/tb_rnb_mult.sv
`timescale 1ns/1ps
module tb_rnb_mult;
  localparam int unsigned M = 5;
  localparam int unsigned P = 2 * M + 1;
  localparam int unsigned N = 1 << M;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [M-1:0] b_in;
  logic         a_bit;
  logic         busy, done;
  logic [M-1:0] prod;

  always #2 clk = ~clk;

  rnb_mult #(.M(M)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .b_in(b_in),
    .a_bit(a_bit), .busy(busy), .done(done), .prod(prod)
  );

  typedef struct {
    logic [M-1:0] a;
    logic [M-1:0] b;
    logic [M-1:0] exp;
  } item_t;

  item_t        sb_q[$];
  logic [M-1:0] res [N][N];
  int           n_tests = 0;
  int           n_fail  = 0;
  int           n_done  = 0;
  bit           finished = 0;

  task automatic chk(input bit ok, input string req, input logic [M-1:0] act,
                     input logic [M-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic int unsigned fold(input int unsigned x);
    int unsigned r;
    r = x % P;
    return (r > M) ? P - r : r;
  endfunction

  function automatic logic cf(input logic [M-1:0] v, input int unsigned idx);
    return (idx == 0) ? 1'b0 : v[idx-1];
  endfunction

  // Behavioural model of the product formula (R4).
  function automatic logic [M-1:0] model(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] c;
    c = '0;
    for (int k = 1; k <= M; k++)
      for (int i = 1; i <= M; i++)
        if (a[i-1]) c[k-1] ^= cf(b, fold(k + i)) ^ cf(b, fold(k + P - i));
    return c;
  endfunction

  // Driver: pushes the expected item, then feeds the operands.
  task automatic run_mult(input logic [M-1:0] a, input logic [M-1:0] b, input bit poke);
    item_t it;
    it.a = a; it.b = b; it.exp = model(a, b);
    sb_q.push_back(it);
    @(posedge clk);
    start = 1'b1; b_in = b;
    @(posedge clk);
    start = 1'b0; b_in = ~b;
    chk(busy === 1'b1 && prod === '0, "R2", prod, '0);
    a_bit = a[0];
    for (int i = 1; i < M; i++) begin
      @(posedge clk);
      start = (poke && i == 2);
      if (poke && i == 2) b_in = ~a;
      a_bit = a[i];
      if (i == M - 1) chk(busy === 1'b1 && done === 1'b0, "R3 early", {4'b0, done}, '0);
      if (poke && i == 3) chk(busy === 1'b1, "R5 busy kept", {4'b0, busy}, 5'd1);
    end
    @(posedge clk);
    a_bit = 1'b0; start = 1'b0;
    repeat (3) @(posedge clk);
    chk(prod === it.exp, "R6 hold", prod, it.exp);
    chk(busy === 1'b0, "R6 idle", {4'b0, busy}, '0);
  endtask

  // Monitor: pops expected items when done is seen.
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && done === 1'b1) begin
        item_t it;
        n_done++;
        if (sb_q.size() == 0) begin
          chk(1'b0, "R3 spurious done", prod, '0);
        end else begin
          it = sb_q.pop_front();
          chk(prod === it.exp, "R4 product", prod, it.exp);
          res[it.a][it.b] = prod;
        end
        @(posedge clk);
        chk(done === 1'b0, "R3 pulse width", {4'b0, done}, '0);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; b_in = '0; a_bit = 1'b0;
    repeat (3) @(posedge clk);
    chk(busy === 1'b0 && done === 1'b0 && prod === '0, "R1 in reset", prod, '0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    chk(busy === 1'b0 && done === 1'b0 && prod === '0, "R1 after reset", prod, '0);

    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++)
        run_mult(M'(a), M'(b), (a % 7) == 3);

    repeat (4) @(posedge clk);
    chk(n_done == N * N, "R3 done count", M'(n_done), M'(N * N));

    for (int b = 0; b < N; b++)
      chk(res[N-1][b] === M'(b), "R7 identity", res[N-1][b], M'(b));
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++)
        chk(res[a][b] === res[b][a], "R8 commute", res[a][b], res[b][a]);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule